// File: doc/BRIEF.md
# PWM Output Enable Register with Fault Gating

This block holds the enable flags for twelve PWM outputs, grouped as six timer units of two outputs each. Software turns outputs on by writing ones to an enable register and turns them off by writing ones to a separate disable register. Writing zero to either register changes nothing. Each timer unit has its own fault line. While that line is high, the unit's two enables are forced low at once, without waiting for a clock edge. A downstream output stage uses the enable vector to gate its pin drivers.

A cleared enable can mean two things: the output is idle, because software disabled it, or the output is in fault, because a fault line disabled it. A per-output state flag tells these apart. The flag is set from a synchronised copy of the fault line. Software clears it by disabling the output or by enabling it again. Reads of the enable register return the live enable vector one clock after the address is presented.

Top module: `pwm_oe_reg`

## Requirements
- R1: After reset is asserted, all enables, all state flags and the read data are 0.
- R2: A write to the enable register at address 0x00 sets each enable whose data bit is 1. Bit 2u is output 1 of unit u and bit 2u+1 is output 2, with units A to F numbered 0 to 5.
- R3: A data bit of 0 in a write to the enable register or the disable register leaves that enable unchanged.
- R4: The read data is registered. One cycle after address 0x00 is presented, bits 11:0 hold the live enable vector and bits 31:12 read 0. Bits 31:12 ignore writes. Every other address reads 0.
- R5: A write to the disable register at address 0x04 clears each enable whose data bit is 1.
- R6: While fault_i[u] is 1, enables 2u and 2u+1 are 0, with no clock edge needed. The enables of other units are untouched.
- R7: A set write made in a cycle where the unit's fault is high has no effect. The enable stays 0 after the fault falls.
- R8: fault_st_o for a unit's outputs becomes 1 on the third rising clock edge after its fault line rises, and not before. It stays 1 after the fault falls.
- R9: When the synchronised fault is low, a disable write or an enable write with bit i set clears fault_st_o[i] to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| fault_i | input | 6 | Fault line per timer unit, active high |
| oe_o | output | 12 | Output enable per output |
| fault_st_o | output | 12 | 1 = last disable came from a fault, 0 = idle |

## Verification
The enable path is driven with single-bit writes, full and alternating masks, and all-zero writes. These show whether the set, the clear and the no-effect behaviour act per bit, and whether the neighbouring bits are mapped correctly. Faults are raised between clock edges, one unit at a time and several units together. This shows the asynchronous clear apart from a clocked one and checks that faults stay confined to their own unit. A write and a fault in the same cycle test the priority. Timed samples of the state flag around the synchroniser delay tell a correctly staged flag from one that is early or late. The flag is then cleared both by re-enabling and by disabling, which checks that software clears are told apart from fault clears.

// File: rtl/oe_pkg.sv
`timescale 1ns/1ps
package oe_pkg;
  localparam int unsigned N_UNITS_DEF = 6;
  localparam int unsigned OUTS_PER_UNIT_DEF = 2;
  localparam int unsigned ADDR_W_DEF = 8;
  localparam int unsigned DATA_W_DEF = 32;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_EN   = 2'd1,
    REG_DIS  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/oe_fault_sync.sv
`timescale 1ns/1ps
module oe_fault_sync #(
  parameter int unsigned N_UNITS = 6,
  parameter int unsigned STAGES  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_UNITS-1:0] fault_a_i,
  output logic [N_UNITS-1:0] fault_s_o
);
  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-2:0], fault_a_i[u]};
    end
    assign fault_s_o[u] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/oe_bus_port.sv
`timescale 1ns/1ps
module oe_bus_port
  import oe_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_OUT  = 12,
  parameter logic [ADDR_W-1:0] EN_OFS  = 8'h00,
  parameter logic [ADDR_W-1:0] DIS_OFS = 8'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_OUT-1:0]  en_i,
  output logic [N_OUT-1:0]  set_o,
  output logic [N_OUT-1:0]  clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    if (addr_i == EN_OFS)       sel = REG_EN;
    else if (addr_i == DIS_OFS) sel = REG_DIS;
    else                        sel = REG_NONE;
  end

  // reserved write bits above N_OUT are simply not routed
  assign set_o = (we_i && sel == REG_EN)  ? wdata_i[N_OUT-1:0] : '0;
  assign clr_o = (we_i && sel == REG_DIS) ? wdata_i[N_OUT-1:0] : '0;

  always_comb begin
    rd_d = '0;
    if (sel == REG_EN) rd_d[N_OUT-1:0] = en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_d;
  end
endmodule

// File: rtl/oe_out_cell.sv
`timescale 1ns/1ps
module oe_out_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_a_i,
  input  logic fault_s_i,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o,
  output logic fault_st_o
);
  logic clr_a;
  logic en_q;
  logic st_q;

  // fault acts as async clear: holds the flop low while high
  assign clr_a = fault_a_i | ~rst_ni;

  always_ff @(posedge clk_i or posedge clr_a) begin
    if (clr_a)      en_q <= 1'b0;
    else if (clr_i) en_q <= 1'b0;
    else if (set_i) en_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             st_q <= 1'b0;
    else if (fault_s_i)      st_q <= 1'b1;
    else if (set_i || clr_i) st_q <= 1'b0;
  end

  assign en_o       = en_q;
  assign fault_st_o = st_q;
endmodule

// File: rtl/pwm_oe_reg.sv
`timescale 1ns/1ps
module pwm_oe_reg
  import oe_pkg::*;
#(
  parameter int unsigned N_UNITS       = N_UNITS_DEF,
  parameter int unsigned OUTS_PER_UNIT = OUTS_PER_UNIT_DEF,
  parameter int unsigned ADDR_W        = ADDR_W_DEF,
  parameter int unsigned DATA_W        = DATA_W_DEF,
  parameter int unsigned SYNC_STAGES   = SYNC_STAGES_DEF,
  parameter logic [ADDR_W-1:0] EN_OFS  = 8'h00,
  parameter logic [ADDR_W-1:0] DIS_OFS = 8'h04,
  localparam int unsigned N_OUT        = N_UNITS * OUTS_PER_UNIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_UNITS-1:0] fault_i,
  output logic [N_OUT-1:0]  oe_o,
  output logic [N_OUT-1:0]  fault_st_o
);
  logic [N_OUT-1:0]   set_m;
  logic [N_OUT-1:0]   clr_m;
  logic [N_UNITS-1:0] fault_sync;

  oe_bus_port #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N_OUT  (N_OUT),
    .EN_OFS (EN_OFS),
    .DIS_OFS(DIS_OFS)
  ) u_bus (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .we_i   (we_i),
    .wdata_i(wdata_i),
    .en_i   (oe_o),
    .set_o  (set_m),
    .clr_o  (clr_m),
    .rdata_o(rdata_o)
  );

  oe_fault_sync #(
    .N_UNITS(N_UNITS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fault_a_i(fault_i),
    .fault_s_o(fault_sync)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    localparam int unsigned UNIT = i / OUTS_PER_UNIT;
    oe_out_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .fault_a_i (fault_i[UNIT]),
      .fault_s_i (fault_sync[UNIT]),
      .set_i     (set_m[i]),
      .clr_i     (clr_m[i]),
      .en_o      (oe_o[i]),
      .fault_st_o(fault_st_o[i])
    );
  end
endmodule

// File: rtl/oe_reg_chk.sv
`timescale 1ns/1ps
module oe_reg_chk #(
  parameter int unsigned N_UNITS       = 6,
  parameter int unsigned OUTS_PER_UNIT = 2,
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned DATA_W        = 32,
  parameter logic [ADDR_W-1:0] EN_OFS  = 8'h00,
  parameter logic [ADDR_W-1:0] DIS_OFS = 8'h04,
  localparam int unsigned N_OUT        = N_UNITS * OUTS_PER_UNIT
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               we_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [N_UNITS-1:0] fault_i,
  input logic [N_OUT-1:0]   oe_o,
  input logic [N_OUT-1:0]   fault_st_o,
  input logic [N_UNITS-1:0] fault_sync
);
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (oe_o == '0 && fault_st_o == '0));

  assert_read_live_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == EN_OFS) |=> (rdata_o == DATA_W'($past(oe_o))));

  assert_read_other_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != EN_OFS) |=> (rdata_o == '0));

  for (genvar i = 0; i < N_OUT; i++) begin : g_bit
    localparam int unsigned UNIT = i / OUTS_PER_UNIT;

    assert_rise_needs_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(oe_o[i]) |-> $past(we_i && addr_i == EN_OFS && wdata_i[i]));

    assert_disable_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == DIS_OFS && wdata_i[i]) |=> !oe_o[i]);

    assert_fault_forces_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_i[UNIT] |-> !oe_o[i]);

    assert_flag_follows_sync_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_sync[UNIT] |=> fault_st_o[i]);

    assert_sw_clear_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && (addr_i == DIS_OFS || addr_i == EN_OFS) && wdata_i[i] && !fault_sync[UNIT])
      |=> !fault_st_o[i]);
  end
endmodule

bind pwm_oe_reg oe_reg_chk #(
  .N_UNITS      (N_UNITS),
  .OUTS_PER_UNIT(OUTS_PER_UNIT),
  .ADDR_W       (ADDR_W),
  .DATA_W       (DATA_W),
  .EN_OFS       (EN_OFS),
  .DIS_OFS      (DIS_OFS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .fault_i   (fault_i),
  .oe_o      (oe_o),
  .fault_st_o(fault_st_o),
  .fault_sync(fault_sync)
);

// File: tb/sim_pwm_oe_reg.sv
`timescale 1ns/1ps
module sim_pwm_oe_reg;
  localparam logic [7:0] EN_A  = 8'h00;
  localparam logic [7:0] DIS_A = 8'h04;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [5:0]  fault_i = '0;
  logic [11:0] oe_o;
  logic [11:0] fault_st_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  pwm_oe_reg u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .fault_i(fault_i),
    .oe_o(oe_o), .fault_st_o(fault_st_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; we_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic bus_rd(output logic [31:0] d, input logic [7:0] a);
    @(negedge clk_i);
    addr_i = a; we_i = 1'b0;
    @(negedge clk_i);
    d = rdata_o;
  endtask

  task automatic do_reset();
    fault_i = '0; we_i = 1'b0; addr_i = '0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_reset_state();
    bus_wr(EN_A, 32'hFFF);
    rst_ni = 1'b0;
    #1;
    chk("R1 oe after reset", {20'h0, oe_o}, 32'h0);
    @(negedge clk_i);
    chk("R1 flag after reset", {20'h0, fault_st_o}, 32'h0);
    chk("R1 rdata after reset", rdata_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_set_bits();
    logic [31:0] rd;
    bus_wr(EN_A, 32'h001);
    chk("R2 set unit A out1", {20'h0, oe_o}, 32'h001);
    bus_wr(EN_A, 32'h800);
    chk("R2 set unit F out2", {20'h0, oe_o}, 32'h801);
    bus_wr(EN_A, 32'h000);
    chk("R3 zero write to enable", {20'h0, oe_o}, 32'h801);
    bus_wr(DIS_A, 32'h000);
    chk("R3 zero write to disable", {20'h0, oe_o}, 32'h801);
    bus_rd(rd, EN_A);
    chk("R4 live read", rd, 32'h801);
  endtask

  task automatic t_patterns();
    logic [31:0] rd;
    bus_wr(DIS_A, 32'hFFF);
    chk("R5 clear all", {20'h0, oe_o}, 32'h0);
    bus_wr(EN_A, 32'hAAA);
    chk("R2 odd pattern", {20'h0, oe_o}, 32'hAAA);
    bus_wr(EN_A, 32'h555);
    chk("R2 merge even", {20'h0, oe_o}, 32'hFFF);
    bus_wr(DIS_A, 32'h0F0);
    chk("R5 partial clear", {20'h0, oe_o}, 32'hF0F);
    bus_wr(EN_A, 32'hFFFF_F000);
    chk("R4 reserved write ignored", {20'h0, oe_o}, 32'hF0F);
    bus_rd(rd, EN_A);
    chk("R4 reserved read zero", rd, 32'h0000_0F0F);
    bus_rd(rd, 8'h08);
    chk("R4 other address reads zero", rd, 32'h0);
  endtask

  task automatic t_async_fault();
    logic [31:0] rd;
    bus_wr(EN_A, 32'hFFF);
    @(negedge clk_i);
    #2;
    fault_i = 6'b000100;  // unit C between edges
    #1;
    chk("R6 async clear unit C", {20'h0, oe_o}, 32'hFCF);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R8 flag not before third edge", {20'h0, fault_st_o}, 32'h000);
    @(negedge clk_i);
    chk("R8 flag on third edge", {20'h0, fault_st_o}, 32'h030);
    bus_rd(rd, EN_A);
    chk("R4 read reflects fault", rd, 32'h0000_0FCF);
    fault_i = '0;
    repeat (4) @(negedge clk_i);
    chk("R8 flag held after fault falls", {20'h0, fault_st_o}, 32'h030);
    chk("R6 stays cleared after fault", {20'h0, oe_o}, 32'hFCF);
    bus_wr(EN_A, 32'h010);
    chk("R9 re-enable clears flag", {20'h0, fault_st_o}, 32'h020);
    chk("R2 re-enable after fault", {20'h0, oe_o}, 32'hFDF);
  endtask

  task automatic t_multi_fault();
    bus_wr(EN_A, 32'hFFF);
    @(negedge clk_i);
    #3;
    fault_i = 6'b100001;
    #1;
    chk("R6 units A and F cleared", {20'h0, oe_o}, 32'h3FC);
    repeat (3) @(negedge clk_i);
    fault_i = '0;
    repeat (3) @(negedge clk_i);
    chk("R8 flags A and F", {20'h0, fault_st_o & 12'hC03}, 32'hC03);
    bus_wr(DIS_A, 32'hC03);
    chk("R9 disable clears flags", {20'h0, fault_st_o & 12'hC03}, 32'h0);
    chk("R5 disable keeps cleared", {20'h0, oe_o}, 32'h3FC);
  endtask

  task automatic t_write_vs_fault();
    bus_wr(DIS_A, 32'hFFF);
    @(negedge clk_i);
    fault_i = 6'b000010;
    addr_i = EN_A; we_i = 1'b1; wdata_i = 32'h00C;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
    chk("R7 set during fault blocked", {20'h0, oe_o}, 32'h000);
    fault_i = '0;
    repeat (2) @(negedge clk_i);
    chk("R7 still cleared after fault", {20'h0, oe_o}, 32'h000);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset_state();
    do_reset();
    t_set_bits();
    t_patterns();
    do_reset();
    t_async_fault();
    do_reset();
    t_multi_fault();
    do_reset();
    t_write_vs_fault();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule